// File: doc/BRIEF.md
# Broadcast-Nonce Mining Core Array Hub

This block sits between a host and a row of identical nonce-tester cores. The host sends one block configuration: the 256-bit midstate, the last word of the Merkle root, the difficulty bits and the timestamp. The hub holds these values and drives them to every core. The host then sends one global nonce per round. From that single value, each core gets a distinct nonce: the global nonce, plus the core count times an array index strapped on the board, plus the core's position. Several hubs can therefore share one broadcast without overlapping.

A round lasts a fixed number of clocks, 128 by default. The hub counts the cycles of the round. In the last cycle it samples the cores' hit lines. If any core hit, it reports the nonce of the lowest-numbered hitting core. That result stays on the outputs until the next round finishes, a new block is loaded, or reset is applied. Reset is a pulse on the reset line: low, then high, then low. While the line is high, the hub holds everything cleared. Normal operation needs the line low.

Top module: `nonce_array_hub`

## Requirements
- R1: Core k receives nonce = global + CORES*array_scalar + k, computed modulo 2^32. The per-core nonces are packed into `core_nonce`, with core k at bits [32k+31:32k].
- R2: A cycle with `cfg_load` high captures midstate, Merkle tail, bits and time, and the hub presents them on its config outputs. Those outputs hold their values in every other cycle, except while reset is applied.
- R3: `nonce_valid` is accepted when the hub is idle or in the last cycle of a round. Acceptance latches the global nonce and starts a round. `round_first` is high in the round's first cycle, and `busy` is high for exactly ROUND_CYCLES cycles per round. If no nonce is accepted in the last cycle, the hub goes idle.
- R4: `nonce_valid` during any non-last cycle of a round is ignored. The per-core nonces do not change.
- R5: `core_hit` is sampled only in a round's last cycle. Hits in any other cycle have no effect on `found`.
- R6: When several cores hit in the same last cycle, `found_nonce` is the nonce of the lowest-indexed hitting core.
- R7: At each round end, `found` and `found_nonce` are updated. They then hold until the next round end. `found_nonce` is 0 whenever `found` is 0.
- R8: `cfg_load` clears `found`, `found_nonce`, `busy` and the latched global nonce, which stops any round. A `nonce_valid` in the same cycle is ignored.
- R9: In the cycle after the reset line is high, all state is zero, including config outputs and the global nonce. Operation resumes in the cycle after the line returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_line | input | 1 | Pulsed reset, active high, synchronous |
| cfg_load | input | 1 | Capture a new block configuration |
| cfg_midstate | input | 256 | Midstate of the header's first chunk |
| cfg_merkle | input | 32 | Last word of the Merkle root |
| cfg_bits | input | 32 | Difficulty bits |
| cfg_time | input | 32 | Timestamp |
| nonce_valid | input | 1 | Global nonce offered this cycle |
| global_nonce | input | 32 | Broadcast nonce |
| array_scalar | input | SCALAR_W | Strapped array index |
| core_hit | input | CORES | Per-core success lines |
| midstate_o | output | 256 | Held midstate for the cores |
| merkle_o | output | 32 | Held Merkle tail |
| bits_o | output | 32 | Held bits |
| time_o | output | 32 | Held timestamp |
| core_nonce | output | CORES*32 | Packed per-core nonces |
| round_first | output | 1 | First cycle of a round |
| busy | output | 1 | Round in progress |
| found | output | 1 | Last completed round had a hit |
| found_nonce | output | 32 | Winning nonce, or 0 |

## Verification
A wrong cycle counter shows up at once: a round that is too short or too long moves `busy` and the edge where hits are sampled. Both are visible within one round of 128 cycles. A corrupted global-nonce latch or strap sum appears on every lane of `core_nonce` in the cycle after the fault. A broken priority pick only shows when hits overlap, so those patterns are driven on purpose. A result that is cleared too early or kept too long appears on `found` at the next round boundary or during the hold interval.

// File: rtl/nah_pkg.sv
package nah_pkg;
    localparam int MID_W  = 256;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [MID_W-1:0]  midstate;
        logic [WORD_W-1:0] merkle;
        logic [WORD_W-1:0] bits;
        logic [WORD_W-1:0] stamp;
    } blk_cfg_t;
endpackage

// File: rtl/nah_nonce_gen.sv
module nah_nonce_gen #(
    parameter int NONCE_W  = 32,
    parameter int CORES    = 4,
    parameter int SCALAR_W = 8,
    parameter int IDX      = 0
) (
    input  logic [NONCE_W-1:0]  base_nonce,
    input  logic [SCALAR_W-1:0] scalar,
    output logic [NONCE_W-1:0]  lane_nonce
);
    logic [NONCE_W-1:0] stride;

    always_comb begin
        stride     = NONCE_W'(CORES) * NONCE_W'(scalar);
        lane_nonce = base_nonce + stride + NONCE_W'(IDX);
    end
endmodule

// File: rtl/nah_first_hit.sv
module nah_first_hit #(
    parameter int NONCE_W = 32,
    parameter int CORES   = 4
) (
    input  logic [CORES-1:0]         hits,
    input  logic [CORES*NONCE_W-1:0] lanes,
    output logic                     any_hit,
    output logic [NONCE_W-1:0]       winner
);
    always_comb begin
        any_hit = |hits;
        winner  = '0;
        for (int i = CORES - 1; i >= 0; i--) begin
            if (hits[i]) winner = lanes[i*NONCE_W +: NONCE_W];
        end
    end
endmodule

// File: rtl/nonce_array_hub.sv
module nonce_array_hub #(
    parameter int CORES        = 4,
    parameter int NONCE_W      = 32,
    parameter int SCALAR_W     = 8,
    parameter int ROUND_CYCLES = 128
) (
    input  logic                        clk,
    input  logic                        rst_line,
    input  logic                        cfg_load,
    input  logic [nah_pkg::MID_W-1:0]   cfg_midstate,
    input  logic [nah_pkg::WORD_W-1:0]  cfg_merkle,
    input  logic [nah_pkg::WORD_W-1:0]  cfg_bits,
    input  logic [nah_pkg::WORD_W-1:0]  cfg_time,
    input  logic                        nonce_valid,
    input  logic [NONCE_W-1:0]          global_nonce,
    input  logic [SCALAR_W-1:0]         array_scalar,
    input  logic [CORES-1:0]            core_hit,
    output logic [nah_pkg::MID_W-1:0]   midstate_o,
    output logic [nah_pkg::WORD_W-1:0]  merkle_o,
    output logic [nah_pkg::WORD_W-1:0]  bits_o,
    output logic [nah_pkg::WORD_W-1:0]  time_o,
    output logic [CORES*NONCE_W-1:0]    core_nonce,
    output logic                        round_first,
    output logic                        busy,
    output logic                        found,
    output logic [NONCE_W-1:0]          found_nonce
);
    import nah_pkg::*;

    localparam int              CNT_W = $clog2(ROUND_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUND_CYCLES - 1);

    typedef struct packed {
        blk_cfg_t           cfg;
        logic [NONCE_W-1:0] glob;
        logic               run;
        logic [CNT_W-1:0]   cnt;
        logic               found;
        logic [NONCE_W-1:0] fnonce;
    } hub_st_t;

    hub_st_t            st_d, st_q;
    logic               last_cyc;
    logic               any_hit;
    logic [NONCE_W-1:0] win_nonce;

    generate
        for (genvar k = 0; k < CORES; k++) begin : g_lane
            nah_nonce_gen #(
                .NONCE_W (NONCE_W),
                .CORES   (CORES),
                .SCALAR_W(SCALAR_W),
                .IDX     (k)
            ) u_gen (
                .base_nonce(st_q.glob),
                .scalar    (array_scalar),
                .lane_nonce(core_nonce[k*NONCE_W +: NONCE_W])
            );
        end
    endgenerate

    nah_first_hit #(
        .NONCE_W(NONCE_W),
        .CORES  (CORES)
    ) u_pick (
        .hits   (core_hit),
        .lanes  (core_nonce),
        .any_hit(any_hit),
        .winner (win_nonce)
    );

    always_comb begin
        st_d     = st_q;
        last_cyc = st_q.run && (st_q.cnt == LAST);
        if (rst_line) begin
            st_d = '0;
        end else if (cfg_load) begin
            st_d              = '0;
            st_d.cfg.midstate = cfg_midstate;
            st_d.cfg.merkle   = cfg_merkle;
            st_d.cfg.bits     = cfg_bits;
            st_d.cfg.stamp    = cfg_time;
        end else begin
            if (last_cyc) begin
                st_d.found  = any_hit;
                st_d.fnonce = any_hit ? win_nonce : '0;
            end
            if (nonce_valid && (!st_q.run || last_cyc)) begin
                st_d.glob = global_nonce;
                st_d.run  = 1'b1;
                st_d.cnt  = '0;
            end else if (last_cyc) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else if (st_q.run) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign midstate_o  = st_q.cfg.midstate;
    assign merkle_o    = st_q.cfg.merkle;
    assign bits_o      = st_q.cfg.bits;
    assign time_o      = st_q.cfg.stamp;
    assign busy        = st_q.run;
    assign round_first = st_q.run && (st_q.cnt == '0);
    assign found       = st_q.found;
    assign found_nonce = st_q.fnonce;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst_line)
        !cfg_load |=> ($stable(midstate_o) && $stable(merkle_o) && $stable(bits_o) && $stable(time_o)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst_line)
        (busy && !last_cyc && !cfg_load) |=> (busy && st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R4
    glob_hold_chk: assert property (@(posedge clk) disable iff (rst_line)
        (busy && !last_cyc && !cfg_load) |=> $stable(core_nonce));

    // R5
    found_edge_chk: assert property (@(posedge clk) disable iff (rst_line)
        (!last_cyc && !cfg_load) |=> ($stable(found) && $stable(found_nonce)));

    // R7
    zero_nonce_chk: assert property (@(posedge clk) disable iff (rst_line)
        !found |-> (found_nonce == '0));

    // R8
    load_clear_chk: assert property (@(posedge clk) disable iff (rst_line)
        cfg_load |=> (!found && !busy));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst_line |=> (!busy && !found && midstate_o == '0 && time_o == '0));
endmodule

// File: tb/test_nonce_array_hub.sv
module test_nonce_array_hub;
    localparam int  CORES    = 4;
    localparam int  NW       = 32;
    localparam int  SW       = 8;
    localparam int  ROUND    = 128;
    localparam time CLK_PER  = 10;

    logic              clk = 1'b0;
    logic              rst_line = 1'b0;
    logic              cfg_load = 1'b0;
    logic [255:0]      cfg_midstate = '0;
    logic [31:0]       cfg_merkle = '0, cfg_bits = '0, cfg_time = '0;
    logic              nonce_valid = 1'b0;
    logic [NW-1:0]     global_nonce = '0;
    logic [SW-1:0]     array_scalar = '0;
    logic [CORES-1:0]  core_hit = '0;
    logic [255:0]      midstate_o;
    logic [31:0]       merkle_o, bits_o, time_o;
    logic [CORES*NW-1:0] core_nonce;
    logic              round_first, busy, found;
    logic [NW-1:0]     found_nonce;

    nonce_array_hub #(.CORES(CORES), .NONCE_W(NW), .SCALAR_W(SW), .ROUND_CYCLES(ROUND)) i_nonce_array_hub (
        .clk(clk), .rst_line(rst_line), .cfg_load(cfg_load), .cfg_midstate(cfg_midstate),
        .cfg_merkle(cfg_merkle), .cfg_bits(cfg_bits), .cfg_time(cfg_time),
        .nonce_valid(nonce_valid), .global_nonce(global_nonce), .array_scalar(array_scalar),
        .core_hit(core_hit), .midstate_o(midstate_o), .merkle_o(merkle_o), .bits_o(bits_o),
        .time_o(time_o), .core_nonce(core_nonce), .round_first(round_first), .busy(busy),
        .found(found), .found_nonce(found_nonce));

    always #(CLK_PER/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    // behavioural reference
    logic [255:0] m_mid;
    logic [31:0]  m_mer, m_bits, m_time, m_glob, m_fn;
    bit           m_run, m_found;
    int           m_cnt;

    function automatic logic [31:0] lane(logic [31:0] g, int k);
        return g + 32'(CORES) * 32'(array_scalar) + 32'(k);
    endfunction

    always @(posedge clk) begin
        bit last;
        last = m_run && (m_cnt == ROUND - 1);
        if (rst_line) begin
            m_mid = '0; m_mer = '0; m_bits = '0; m_time = '0; m_glob = '0;
            m_fn = '0; m_run = 0; m_found = 0; m_cnt = 0;
        end else if (cfg_load) begin
            m_mid = cfg_midstate; m_mer = cfg_merkle; m_bits = cfg_bits; m_time = cfg_time;
            m_glob = '0; m_fn = '0; m_run = 0; m_found = 0; m_cnt = 0;
        end else begin
            if (last) begin
                m_found = |core_hit;
                m_fn = '0;
                for (int k = CORES - 1; k >= 0; k--) if (core_hit[k]) m_fn = lane(m_glob, k);
            end
            if (nonce_valid && (!m_run || last)) begin
                m_glob = global_nonce; m_run = 1; m_cnt = 0;
            end else if (last) begin
                m_run = 0; m_cnt = 0;
            end else if (m_run) begin
                m_cnt++;
            end
        end
    end

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 midstate", midstate_o, m_mid);
            chk("R2 merkle", 256'(merkle_o), 256'(m_mer));
            chk("R2 bits", 256'(bits_o), 256'(m_bits));
            chk("R2 time", 256'(time_o), 256'(m_time));
            chk("R3 busy", 256'(busy), 256'(m_run));
            chk("R3 round_first", 256'(round_first), 256'(m_run && m_cnt == 0));
            chk("R5 found", 256'(found), 256'(m_found));
            chk("R6 found_nonce", 256'(found_nonce), 256'(m_fn));
            for (int k = 0; k < CORES; k++)
                chk("R1 lane", 256'(core_nonce[k*NW +: NW]), 256'(lane(m_glob, k)));
        end
    end

    task automatic next();
        @(negedge clk);
        #1;
    endtask

    task automatic to_last();
        while (!(m_run && m_cnt == ROUND - 1)) next();
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2 rst_line = 1'b1;
        next(); next(); next();
        rst_line = 1'b0;
        cmp_en = 1'b1;
        // R9 reset state
        chk("R9 busy after reset", 256'(busy), 256'(0));
        chk("R9 found after reset", 256'(found), 256'(0));
        chk("R9 midstate after reset", midstate_o, '0);

        // R8: load with simultaneous nonce
        cfg_load = 1; cfg_midstate = {8{32'hA5A5_0001}}; cfg_merkle = 32'h1111_2222;
        cfg_bits = 32'h1703_a30c; cfg_time = 32'h6500_0000;
        nonce_valid = 1; global_nonce = 32'd55;
        next();
        cfg_load = 0; nonce_valid = 0; cfg_midstate = '0;
        next();
        chk("R8 nonce with load ignored", 256'(busy), 256'(0));
        chk("R2 midstate held", midstate_o, {8{32'hA5A5_0001}});

        // R3 start round
        array_scalar = 8'd3; nonce_valid = 1; global_nonce = 32'd100;
        next();
        nonce_valid = 0;
        chk("R3 round_first", 256'(round_first), 256'(1));
        chk("R1 lane2", 256'(core_nonce[2*NW +: NW]), 256'(32'd114));

        // R4, R5 mid-round stimulus
        repeat (40) next();
        core_hit = 4'b1111; nonce_valid = 1; global_nonce = 32'd999;
        next();
        core_hit = 0; nonce_valid = 0;
        next();
        chk("R4 mid-round nonce ignored", 256'(core_nonce[0 +: NW]), 256'(32'd112));
        chk("R5 mid-round hit ignored", 256'(found), 256'(0));

        // R6 priority, back-to-back round
        to_last();
        core_hit = 4'b0110; nonce_valid = 1; global_nonce = 32'd200;
        next();
        core_hit = 0; nonce_valid = 0;
        chk("R6 lowest hit found", 256'(found), 256'(1));
        chk("R6 lowest hit nonce", 256'(found_nonce), 256'(32'd113));
        chk("R3 back-to-back start", 256'(round_first), 256'(1));
        chk("R1 new lane0", 256'(core_nonce[0 +: NW]), 256'(32'd212));
        repeat (30) next();
        chk("R7 result held", 256'(found_nonce), 256'(32'd113));

        // R7 no-hit round end, idle
        to_last();
        next();
        chk("R7 found cleared at end", 256'(found), 256'(0));
        chk("R7 nonce zero", 256'(found_nonce), 256'(0));
        chk("R3 idle after end", 256'(busy), 256'(0));
        repeat (5) next();

        // R1 wraparound
        nonce_valid = 1; global_nonce = 32'hFFFF_FFFE;
        next();
        nonce_valid = 0;
        chk("R1 wrap lane3", 256'(core_nonce[3*NW +: NW]), 256'(32'h0000_000D));
        to_last();
        core_hit = 4'b1000;
        next();
        core_hit = 0;
        chk("R1 wrap winner", 256'(found_nonce), 256'(32'h0000_000D));

        // R8 load during round clears result
        nonce_valid = 1; global_nonce = 32'd7;
        next();
        nonce_valid = 0;
        repeat (10) next();
        cfg_load = 1; cfg_midstate = {8{32'h0BAD_F00D}}; cfg_time = 32'h6500_0100;
        next();
        cfg_load = 0;
        chk("R8 found cleared", 256'(found), 256'(0));
        chk("R8 round stopped", 256'(busy), 256'(0));
        chk("R2 new midstate", midstate_o, {8{32'h0BAD_F00D}});

        // R9 reset pulse mid-round
        nonce_valid = 1; global_nonce = 32'd1;
        next();
        nonce_valid = 0;
        repeat (5) next();
        rst_line = 1;
        next(); next();
        rst_line = 0;
        chk("R9 busy cleared", 256'(busy), 256'(0));
        chk("R9 config cleared", 256'(time_o), 256'(0));
        nonce_valid = 1; global_nonce = 32'd40;
        next();
        nonce_valid = 0;
        chk("R9 resumes after pulse", 256'(busy), 256'(1));
        repeat (3) next();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule